// File: doc/BRIEF.md
# Direct-Mapped Data Cache Access Stage with Deferred Store Buffer

This block is the memory-access stage of a simple in-order pipeline. It is a direct-mapped, virtually tagged data cache. Line state (valid, dirty, tag) lives in one array and line words live in another. A load reads both arrays in the same cycle and compares the stored tag with the tag field of its address. On a hit the word is registered and returned one cycle later.

A store only checks the tag in its access cycle. The store itself goes into a single-entry address/data buffer. The buffered word is written into the data array when the next store is accepted. A load whose word address equals the buffered address is served from the buffer instead of the array, and its timing does not change.

On a miss the pipeline is held through `stall_o` while a refill controller runs. If the buffered store targets the line being replaced, the controller first commits that store. If the victim line is dirty, the controller writes it back. It then fetches the new line one word per request/acknowledge beat. The pipeline keeps its request asserted, and the request hits once the refill ends.

Top module: `dcache_sb_top`

## Requirements
- R1: A load hit (hit_o high with req_valid_i high and req_store_i low, stall_o low) is accepted at that clock edge. One cycle later resp_valid_o is high for one cycle, and resp_data_o holds the addressed word.
- R2: A request whose line is absent (invalid, or tag bits [31:8] differ) drives hit_o low and stall_o high in the same cycle. No response is produced until the refilled request is accepted.
- R3: A refill reads the four words of the missing line from memory, word addresses ascending from the 16-byte aligned line base, with mem_we_o low. Each beat holds mem_req_o, mem_addr_o and mem_we_o steady until mem_ack_i; read data is taken on mem_rdata_i in the ack cycle.
- R4: When the victim line is dirty, all four of its words are written to memory (mem_we_o high, ascending addresses, old tag) before any fill read of the new line.
- R5: A store to a resident line is accepted without stall. A store to an absent line first refills the line and is then accepted. A store produces no resp_valid_o.
- R6: A load whose full address equals that of the buffered, still-pending store returns the buffered data. A load to another word of the same line returns the array word.
- R7: Each accepted store commits the previously buffered store to the data array. Consecutive stores to one word therefore leave the latest value visible, and the earlier committed value reaches memory on eviction.
- R8: When a miss replaces the line that a pending buffered store targets, that store is committed first and the line is written back, even if the line was otherwise clean. The buffer is empty afterwards.
- R9: A clean or invalid victim produces no memory write.
- R10: After reset stall_o, hit_o, resp_valid_o and mem_req_o are low, and every line is invalid.
- R11: After a refill each word of the new line reads back the value memory held, and the retried request hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request present, held while stall_o is high |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Word-aligned virtual byte address |
| req_wdata_i | input | 32 | Store data |
| hit_o | output | 1 | Tag hit for the current request while not refilling |
| stall_o | output | 1 | Pipeline hold: miss detected or refill in progress |
| resp_valid_o | output | 1 | Load result valid (one cycle after acceptance) |
| resp_data_o | output | 32 | Load result |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write-back write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ack_i | input | 1 | Beat acknowledge |
| mem_rdata_i | input | 32 | Fill data, valid with mem_ack_i |

## Verification
The first load to a line checks cold-miss refill order with no write traffic, and a second load to that line checks the hit path. A store followed by loads to the same word and to a neighbour word shows whether results come from the buffer or the array. Three evictions of the same index tell apart a line dirtied by a committed store, a clean line, and a line made dirty only by the buffer drain. Each is judged by the memory write log and the memory image afterwards. Repeated stores to one word, followed by reloads after eviction, show that commits keep program order and that a drained buffer never bypasses a later load.

// File: rtl/dcache_sb_pkg.sv
package dcache_sb_pkg;
  typedef enum logic [1:0] {
    RF_IDLE,
    RF_WB,
    RF_FILL
  } rf_state_e;
endpackage

// File: rtl/dcache_sb_tags.sv
module dcache_sb_tags #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 24,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             dirty_set_i,
  input  logic [IDX_W-1:0] dirty_idx_i
);
  logic [NUM_LINES-1:0] vld_q, drt_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      drt_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) tag_q[i] <= '0;
    end else begin
      if (fill_i) begin
        vld_q[fill_idx_i] <= 1'b1;
        drt_q[fill_idx_i] <= 1'b0;
        tag_q[fill_idx_i] <= fill_tag_i;
      end
      if (dirty_set_i) drt_q[dirty_idx_i] <= 1'b1;
    end
  end

  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_dirty_o = drt_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];

  // R11
  fill_marks_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !dirty_set_i |=> vld_q[$past(fill_idx_i)] && !drt_q[$past(fill_idx_i)]);
endmodule

// File: rtl/dcache_sb_data.sv
module dcache_sb_data #(
  parameter int WORDS    = 64,
  parameter int DATA_W   = 32,
  localparam int WADDR_W = $clog2(WORDS)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [WADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0]  rda_o,
  input  logic [WADDR_W-1:0] rb_i,
  output logic [DATA_W-1:0]  rdb_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rda_o = mem_q[ra_i];
  assign rdb_o = mem_q[rb_i];
endmodule

// File: rtl/dcache_sb_stbuf.sv
module dcache_sb_stbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              drain_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (capture_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end else if (drain_i) begin
      valid_o <= 1'b0;
    end
  end

  // R5
  capture_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> valid_o && addr_o == $past(addr_i) && data_o == $past(data_i));
  // R8
  drain_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i && !capture_i |=> !valid_o);
endmodule

// File: rtl/dcache_sb_refill.sv
module dcache_sb_refill
  import dcache_sb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  localparam int BYTE_W    = $clog2(DATA_W / 8),
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - WORD_W - BYTE_W,
  localparam int WADDR_W   = IDX_W + WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   miss_idx_i,
  input  logic [TAG_W-1:0]   miss_tag_i,
  input  logic               victim_dirty_i,
  input  logic [TAG_W-1:0]   victim_tag_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [WADDR_W-1:0] wb_raddr_o,
  input  logic [DATA_W-1:0]  wb_rdata_i,
  output logic               fill_we_o,
  output logic [WADDR_W-1:0] fill_waddr_o,
  output logic [DATA_W-1:0]  fill_wdata_o,
  output logic               tag_fill_o,
  output logic [IDX_W-1:0]   fill_idx_o,
  output logic [TAG_W-1:0]   fill_tag_o
);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(LINE_WORDS - 1);
  localparam int BEAT_BYTES = DATA_W / 8;

  rf_state_e         state_q, state_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q, vtag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      tag_q   <= '0;
      vtag_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == RF_IDLE && start_i) begin
        idx_q  <= miss_idx_i;
        tag_q  <= miss_tag_i;
        vtag_q <= victim_tag_i;
      end
    end
  end

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    fill_we_o   = 1'b0;
    tag_fill_o  = 1'b0;
    unique case (state_q)
      RF_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = victim_dirty_i ? RF_WB : RF_FILL;
      end
      RF_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {vtag_q, idx_q, cnt_q, {BYTE_W{1'b0}}};
        mem_wdata_o = wb_rdata_i;
        if (mem_ack_i) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) state_d = RF_FILL;
        end
      end
      RF_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {tag_q, idx_q, cnt_q, {BYTE_W{1'b0}}};
        if (mem_ack_i) begin
          fill_we_o = 1'b1;
          cnt_d     = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            tag_fill_o = 1'b1;
            state_d    = RF_IDLE;
          end
        end
      end
      default: state_d = RF_IDLE;
    endcase
  end

  assign busy_o       = state_q != RF_IDLE;
  assign wb_raddr_o   = {idx_q, cnt_q};
  assign fill_waddr_o = {idx_q, cnt_q};
  assign fill_wdata_o = mem_rdata_i;
  assign fill_idx_o   = idx_q;
  assign fill_tag_o   = tag_q;

  // R3
  fill_ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RF_FILL && mem_ack_i && cnt_q != LAST
    |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(BEAT_BYTES));
  // R4
  wb_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RF_WB && mem_ack_i && cnt_q == LAST |=> state_q == RF_FILL && cnt_q == '0);
endmodule

// File: rtl/dcache_sb_top.sv
module dcache_sb_top #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              hit_o,
  output logic              stall_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int WORD_W  = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - WORD_W - BYTE_W;
  localparam int WADDR_W = IDX_W + WORD_W;
  localparam int WORDS   = NUM_LINES * LINE_WORDS;

  logic [TAG_W-1:0]   req_tag, ln_tag, fill_tag;
  logic [IDX_W-1:0]   req_idx, sb_idx, fill_idx;
  logic [WADDR_W-1:0] req_waddr, sb_waddr, wb_raddr, fill_waddr, arr_waddr;
  logic               ln_valid, ln_dirty, busy, tag_match, miss;
  logic               st_acc, ld_acc, sb_victim, commit, victim_dirty;
  logic               sb_valid, fill_we, tag_fill, arr_we;
  logic [ADDR_W-1:0]  sb_addr;
  logic [DATA_W-1:0]  sb_data, arr_rdata, wb_rdata, fill_wdata, arr_wdata;

  assign req_tag   = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx   = req_addr_i[BYTE_W+WORD_W +: IDX_W];
  assign req_waddr = req_addr_i[BYTE_W +: WADDR_W];
  assign sb_idx    = sb_addr[BYTE_W+WORD_W +: IDX_W];
  assign sb_waddr  = sb_addr[BYTE_W +: WADDR_W];

  dcache_sb_tags #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i    (req_idx),
    .rd_valid_o  (ln_valid),
    .rd_dirty_o  (ln_dirty),
    .rd_tag_o    (ln_tag),
    .fill_i      (tag_fill),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .dirty_set_i (commit),
    .dirty_idx_i (sb_idx)
  );

  dcache_sb_data #(.WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i,
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .ra_i    (req_waddr),
    .rda_o   (arr_rdata),
    .rb_i    (wb_raddr),
    .rdb_o   (wb_rdata)
  );

  // access-cycle decisions
  assign tag_match    = ln_valid && (ln_tag == req_tag);
  assign hit_o        = req_valid_i && !busy && tag_match;
  assign miss         = req_valid_i && !busy && !tag_match;
  assign stall_o      = busy || miss;
  assign st_acc       = hit_o && req_store_i;
  assign ld_acc       = hit_o && !req_store_i;
  // a buffered store always targets a resident line; drain it before that line leaves
  assign sb_victim    = miss && sb_valid && (sb_idx == req_idx);
  assign commit       = (st_acc && sb_valid) || sb_victim;
  assign victim_dirty = ln_valid && (ln_dirty || sb_victim);

  assign arr_we    = commit || fill_we;
  assign arr_waddr = commit ? sb_waddr : fill_waddr;
  assign arr_wdata = commit ? sb_data  : fill_wdata;

  dcache_sb_stbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stbuf (
    .clk_i, .rst_ni,
    .capture_i (st_acc),
    .drain_i   (sb_victim),
    .addr_i    (req_addr_i),
    .data_i    (req_wdata_i),
    .valid_o   (sb_valid),
    .addr_o    (sb_addr),
    .data_o    (sb_data)
  );

  dcache_sb_refill #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS)
  ) u_refill (
    .clk_i, .rst_ni,
    .start_i        (miss),
    .miss_idx_i     (req_idx),
    .miss_tag_i     (req_tag),
    .victim_dirty_i (victim_dirty),
    .victim_tag_i   (ln_tag),
    .busy_o         (busy),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .wb_raddr_o     (wb_raddr),
    .wb_rdata_i     (wb_rdata),
    .fill_we_o      (fill_we),
    .fill_waddr_o   (fill_waddr),
    .fill_wdata_o   (fill_wdata),
    .tag_fill_o     (tag_fill),
    .fill_idx_o     (fill_idx),
    .fill_tag_o     (fill_tag)
  );

  // writeback-stage result register; buffered store wins over array word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_data_o  <= '0;
    end else begin
      resp_valid_o <= ld_acc;
      if (ld_acc) resp_data_o <= (sb_valid && sb_addr == req_addr_i) ? sb_data : arr_rdata;
    end
  end

  // R1
  resp_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(hit_o && !req_store_i));
  // R2
  miss_holds_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !hit_o |-> stall_o);
  // R3
  beat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R8
  no_fill_over_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !(sb_valid && sb_idx == fill_idx));
endmodule

// File: tb/dcache_sb_top_tb_top.sv
module dcache_sb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        hit_o, stall_o, resp_valid_o;
  logic [31:0] resp_data_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_chk = 0, n_fail = 0, cyc = 0, dly = 0;
  bit done = 0;
  logic [31:0] mem_m [1024];
  logic [31:0] wlog [64];
  logic [31:0] rlog [64];
  int wn = 0, rn = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dcache_sb_top dut_i (.*);

  function automatic logic [31:0] init_w(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  initial for (int i = 0; i < 1024; i++) mem_m[i] = init_w(32'(i) << 2);

  // memory responder: two-cycle latency per beat, logs every beat
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_ack_i = 1'b0;
      dly = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
    end else if (mem_req_o) begin
      if (dly == 1) begin
        dly = 0;
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          mem_m[mem_addr_o[11:2]] = mem_wdata_o;
          if (wn < 64) wlog[wn] = mem_addr_o;
          wn++;
        end else begin
          mem_rdata_i = mem_m[mem_addr_o[11:2]];
          if (rn < 64) rlog[rn] = mem_addr_o;
          rn++;
        end
      end else dly++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic st, input logic [31:0] a, input logic [31:0] wd,
                        output logic miss, output logic hit,
                        output logic [31:0] rd, output logic rv);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_store_i = st;
    req_addr_i  = a;
    req_wdata_i = wd;
    #1;
    miss = stall_o;
    while (stall_o) begin
      @(negedge clk_i);
      #1;
    end
    hit = hit_o;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
    rv = resp_valid_o;
    rd = resp_data_o;
  endtask

  // checks a log slice is the four ascending words of a line
  function automatic logic [31:0] line_seq_ok(input logic is_w, input int start,
                                              input logic [31:0] base);
    for (int k = 0; k < 4; k++) begin
      if (is_w ? (wlog[start+k] !== base + 32'(4*k)) : (rlog[start+k] !== base + 32'(4*k)))
        return 32'd0;
    end
    return 32'd1;
  endfunction

  logic m, h, rv;
  logic [31:0] rd;

  task automatic t_reset();
    check("R10 stall_o", {31'd0, stall_o}, 32'd0);
    check("R10 hit_o", {31'd0, hit_o}, 32'd0);
    check("R10 resp_valid_o", {31'd0, resp_valid_o}, 32'd0);
    check("R10 mem_req_o", {31'd0, mem_req_o}, 32'd0);
  endtask

  task automatic t_cold_load();
    int r0 = rn, w0 = wn;
    access(1'b0, 32'h48, '0, m, h, rd, rv);
    check("R2 cold load stalls", {31'd0, m}, 32'd1);
    check("R3 four fill beats", 32'(rn - r0), 32'd4);
    check("R3 fill order", line_seq_ok(1'b0, r0, 32'h40), 32'd1);
    check("R9 invalid victim no write", 32'(wn - w0), 32'd0);
    check("R11 retried load hits", {31'd0, h}, 32'd1);
    check("R1 resp_valid", {31'd0, rv}, 32'd1);
    check("R11 fill data", rd, init_w(32'h48));
  endtask

  task automatic t_load_hit();
    int r0 = rn;
    access(1'b0, 32'h4C, '0, m, h, rd, rv);
    check("R1 hit no stall", {31'd0, m}, 32'd0);
    check("R1 hit data", rd, init_w(32'h4C));
    check("R1 no memory traffic", 32'(rn - r0), 32'd0);
  endtask

  task automatic t_store_bypass();
    int r0 = rn;
    access(1'b1, 32'h44, 32'hDEAD0001, m, h, rd, rv);
    check("R5 store hit no stall", {31'd0, m}, 32'd0);
    check("R5 store no response", {31'd0, rv}, 32'd0);
    check("R5 store no memory traffic", 32'(rn - r0), 32'd0);
    access(1'b0, 32'h44, '0, m, h, rd, rv);
    check("R6 load from buffer", rd, 32'hDEAD0001);
    access(1'b0, 32'h40, '0, m, h, rd, rv);
    check("R6 neighbour from array", rd, init_w(32'h40));
  endtask

  task automatic t_store_miss();
    int r0 = rn;
    access(1'b1, 32'h84, 32'hDEAD0003, m, h, rd, rv);
    check("R5 store miss stalls", {31'd0, m}, 32'd1);
    check("R5 store miss refills", 32'(rn - r0), 32'd4);
    check("R5 store accepted after fill", {31'd0, h}, 32'd1);
    access(1'b0, 32'h84, '0, m, h, rd, rv);
    check("R6 buffered store forwarded", rd, 32'hDEAD0003);
  endtask

  task automatic t_dirty_evict();
    int w0 = wn, r0 = rn;
    access(1'b0, 32'h140, '0, m, h, rd, rv);
    check("R4 dirty victim written", 32'(wn - w0), 32'd4);
    check("R4 write order", line_seq_ok(1'b1, w0, 32'h40), 32'd1);
    check("R7 committed store in memory", mem_m[32'h44 >> 2], 32'hDEAD0001);
    check("R4 fill follows", line_seq_ok(1'b0, r0, 32'h140), 32'd1);
    check("R11 new line data", rd, init_w(32'h140));
  endtask

  task automatic t_clean_evict();
    int w0 = wn;
    access(1'b0, 32'h244, '0, m, h, rd, rv);
    check("R9 clean victim no write", 32'(wn - w0), 32'd0);
    check("R11 clean evict data", rd, init_w(32'h244));
  endtask

  task automatic t_drain_evict();
    int w0 = wn;
    access(1'b0, 32'h188, '0, m, h, rd, rv);
    check("R8 drained line written", 32'(wn - w0), 32'd4);
    check("R8 buffered data in memory", mem_m[32'h84 >> 2], 32'hDEAD0003);
    check("R8 load data", rd, init_w(32'h188));
    access(1'b0, 32'h84, '0, m, h, rd, rv);
    check("R8 reload after drain misses", {31'd0, m}, 32'd1);
    check("R8 reload value", rd, 32'hDEAD0003);
    access(1'b0, 32'h44, '0, m, h, rd, rv);
    check("R7 reload committed value", rd, 32'hDEAD0001);
  endtask

  task automatic t_repeat_store();
    access(1'b1, 32'h300, 32'hDEAD0004, m, h, rd, rv);
    access(1'b1, 32'h300, 32'hDEAD0005, m, h, rd, rv);
    check("R7 second store no stall", {31'd0, m}, 32'd0);
    access(1'b0, 32'h300, '0, m, h, rd, rv);
    check("R7 latest store visible", rd, 32'hDEAD0005);
    access(1'b1, 32'h304, 32'hDEAD0006, m, h, rd, rv);
    access(1'b0, 32'h300, '0, m, h, rd, rv);
    check("R7 committed latest in array", rd, 32'hDEAD0005);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    t_reset();
    t_cold_load();
    t_load_hit();
    t_store_bypass();
    t_store_miss();
    t_dirty_evict();
    t_clean_evict();
    t_drain_evict();
    t_repeat_store();
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule